// File: doc/BRIEF.md
# Keypad Controller Command Decoder

This block sits behind a serial slave front end and turns its byte stream into operations on a small keypad-controller register file. The front end reports a start condition, every byte the master writes, and every byte the master asks to read. After a start the first written byte names a command. Each byte that follows is a parameter, and its position in the transaction sets its meaning. A read transaction returns bytes of the register that the last command selected, chosen by byte position. Some readback values are reshaped before they leave the block.

The block holds the configuration, active-time, debounce, keypad-size, clock and the three 16-bit GPIO registers (pull, direction, state). It also holds a sticky error register and an interrupt status register that drives an active-low interrupt line. Every parameter is checked for legality. A command is retired once its last parameter is taken, so any further parameter byte counts as a fault. The key FIFO is a neighbouring block. This decoder sends it clear, pop and peek requests together with the byte index, and passes the FIFO's byte back out on reads.

Top module: `kpc_cmd_decoder`

## Requirements
- R1: After reset: configuration 0x80, status 0x10 (bit 4 means not initialised), active time 125, debounce 3, keypad size 0x33, clock 0x08, error 0x00, GPIO registers 0x0000. `irq_n_o` is low.
- R2: A start condition sets the byte index to zero. The first byte written after a start is latched as the command. Each later byte written or read advances the index by one.
- R3: A parameter to command 0x81 stores the configuration, clears status, pulses `fifo_clear_o` in that cycle and retires the command. A read under 0x92 returns only bits 3:0 of the configuration, with bits 7:4 zero.
- R4: Command 0x83 with parameter 0xAA restores the R1 values of configuration, status, active time, debounce, keypad size and clock. The error register and the GPIO registers keep their values. Any other parameter leaves these registers unchanged and raises bad parameter.
- R5: Commands 0x84/0x85/0x86 write pull/direction/state. Parameter 0 loads bits 7:0 and clears bits 15:8. Parameter 1 ORs its value into bits 15:8 and retires the command. Reads under 0x87/0x88 return direction/state bits 7:0 at index 0, bits 15:8 at index 1, and 0x00 after that.
- R6: Command 0x8B stores the active time. Command 0x8F stores the debounce time, and a value of zero is stored but also raises bad parameter. Both commands retire after one parameter.
- R7: Command 0x90 stores the keypad size. It raises bad parameter when bits 3:0 lie outside 3..12 or bits 7:4 lie outside 3..8. A read under 0x91 returns the stored size.
- R8: Command 0x93 stores the clock byte and raises bad parameter when bits 1:0 are 01 or 10. A read under 0x94 returns the stored byte with bits 1:0 forced to 10.
- R9: A parameter byte that arrives while no command is live (after retirement) raises bad parameter, which is error bit 0.
- R10: A parameter to a code with no write meaning, or a read under a code with no read meaning or with no live command, raises unknown command (error bit 1) and reads as 0x00. Any raised error also sets status bit 3.
- R11: A read under 0x82 returns status at index 0. It clears status unless status bit 4 is set. `irq_n_o` is low exactly while status is nonzero.
- R12: A read under 0x80 returns 0x00 at index 0, 0x04 at index 1 and 0x00 after that.
- R13: A read under 0x89 pulses `fifo_pop_o`, and a read under 0x8A pulses `fifo_peek_o`. In both cases `fifo_idx_o` carries the byte index and the returned byte is `fifo_data_i`.
- R14: Error bits are sticky and are cleared only by the reset input. A read under 0x8C returns the error register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start condition seen by the front end |
| wr_valid_i | input | 1 | Master wrote a byte this cycle |
| wr_data_i | input | 8 | Written byte |
| rd_req_i | input | 1 | Master reads a byte this cycle |
| rd_data_o | output | 8 | Byte returned while `rd_req_i` is high |
| irq_n_o | output | 1 | Active-low interrupt, low while status is nonzero |
| fifo_clear_o | output | 1 | Empty the key FIFO |
| fifo_pop_o | output | 1 | Advance the key FIFO by one entry |
| fifo_peek_o | output | 1 | Look at a FIFO entry without advancing |
| fifo_idx_o | output | IDX_W | Current byte index, used as the peek offset |
| fifo_data_i | input | 8 | Byte supplied by the key FIFO |
| cfg_o | output | 8 | Configuration register |
| active_time_o | output | 8 | Active-time register |
| debounce_o | output | 8 | Debounce register |
| key_size_o | output | 8 | Keypad size register |
| clock_o | output | 8 | Clock register |
| gpio_pull_o | output | 16 | GPIO pull register |
| gpio_dir_o | output | 16 | GPIO direction register |
| gpio_state_o | output | 16 | GPIO state register |

## Verification
A wrong command or byte index shows on the very next read, as a byte from the wrong register or at the wrong position. It can also show as an unexpected error, which pulls `irq_n_o` low one cycle after the offending byte. A retirement that is missed or premature shows up when the extra parameter byte either raises a spurious fault or fails to raise one. A register update that goes wrong is visible on the register outputs one cycle after the parameter byte. Status clearing is visible on the interrupt line in the cycle after the status read.

// File: rtl/kpc_pkg.sv
// Shared command codes, reset values and error/status bit positions for
// the keypad controller command decoder.
package kpc_pkg;

    typedef enum logic [7:0] {
        OP_ID_RD     = 8'h80,
        OP_CFG_WR    = 8'h81,
        OP_STAT_RD   = 8'h82,
        OP_SOFT_RST  = 8'h83,
        OP_PULL_WR   = 8'h84,
        OP_DIR_WR    = 8'h85,
        OP_STATE_WR  = 8'h86,
        OP_DIR_RD    = 8'h87,
        OP_STATE_RD  = 8'h88,
        OP_FIFO_POP  = 8'h89,
        OP_FIFO_PEEK = 8'h8A,
        OP_ACT_WR    = 8'h8B,
        OP_ERR_RD    = 8'h8C,
        OP_ROT_RD    = 8'h8E,
        OP_DEB_WR    = 8'h8F,
        OP_SIZE_WR   = 8'h90,
        OP_SIZE_RD   = 8'h91,
        OP_CFG_RD    = 8'h92,
        OP_CLK_WR    = 8'h93,
        OP_CLK_RD    = 8'h94
    } kpc_op_e;

    localparam logic [7:0]  RST_CFG     = 8'h80;
    localparam logic [7:0]  RST_STATUS  = 8'h10;
    localparam logic [7:0]  RST_ACTIVE  = 8'd125;
    localparam logic [7:0]  RST_DEBOUNCE = 8'd3;
    localparam logic [7:0]  RST_SIZE    = 8'h33;
    localparam logic [7:0]  RST_CLOCK   = 8'h08;
    localparam logic [7:0]  RESET_KEY   = 8'hAA;
    localparam logic [15:0] ID_WORD     = 16'h0400;

    localparam int ERR_BADPAR = 0;
    localparam int ERR_CMDUNK = 1;
    localparam int ST_ERROR   = 3;
    localparam int ST_NOINIT  = 4;

endpackage

// File: rtl/kpc_cmd_track.sv
// Command and byte-index tracker.
// Latches the first written byte after a start as the command, keeps a
// "live" flag until the register file retires the command, and counts
// bytes (written or read) since the last start, saturating at the top.
// Assumes start_i never coincides with a data byte.
module kpc_cmd_track #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             wr_valid_i,
    input  logic [7:0]       wr_data_i,
    input  logic             rd_req_i,
    input  logic             retire_i,
    output logic [7:0]       cmd_o,
    output logic             live_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [IDX_W-1:0] IDX_ZERO = '0;
    localparam logic [IDX_W-1:0] IDX_ONE  = 1;
    localparam logic [IDX_W-1:0] IDX_TOP  = '1;

    logic [7:0]       cmd_q;
    logic             live_q;
    logic [IDX_W-1:0] idx_q;

    // Command latch, live flag and byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= 8'h00;
            live_q <= 1'b0;
            idx_q  <= IDX_ZERO;
        end else if (start_i) begin
            idx_q <= IDX_ZERO;
        end else begin
            if (wr_valid_i && idx_q == IDX_ZERO) begin
                cmd_q  <= wr_data_i;
                live_q <= 1'b1;
            end else if (retire_i) begin
                live_q <= 1'b0;
            end
            if ((wr_valid_i || rd_req_i) && idx_q != IDX_TOP)
                idx_q <= idx_q + IDX_ONE;
        end
    end

    assign cmd_o  = cmd_q;
    assign live_o = live_q;
    assign idx_o  = idx_q;

    assert_index_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> idx_q == IDX_ZERO);

    assert_command_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && wr_valid_i && idx_q == IDX_ZERO) |=> (live_q && cmd_q == $past(wr_data_i)));

    assert_retire_drops_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && retire_i && !(wr_valid_i && idx_q == IDX_ZERO)) |=> !live_q);

endmodule

// File: rtl/kpc_param_check.sv
// Parameter legality checks for the keypad controller.
// Purely combinational; the caller decides which check applies to the
// current command. Keypad bounds are parameters.
module kpc_param_check #(
    parameter int LO_MIN = 3,
    parameter int LO_MAX = 12,
    parameter int HI_MIN = 3,
    parameter int HI_MAX = 8
) (
    input  logic [7:0] val_i,
    output logic       deb_bad_o,
    output logic       size_bad_o,
    output logic       clk_bad_o,
    output logic       key_ok_o
);

    localparam logic [3:0] LO_MIN_V = 4'(LO_MIN);
    localparam logic [3:0] LO_MAX_V = 4'(LO_MAX);
    localparam logic [3:0] HI_MIN_V = 4'(HI_MIN);
    localparam logic [3:0] HI_MAX_V = 4'(HI_MAX);

    // Evaluate each check on the incoming byte.
    always_comb begin
        deb_bad_o  = (val_i == 8'h00);
        size_bad_o = (val_i[3:0] < LO_MIN_V) || (val_i[3:0] > LO_MAX_V) ||
                     (val_i[7:4] < HI_MIN_V) || (val_i[7:4] > HI_MAX_V);
        clk_bad_o  = (val_i[1:0] == 2'b01) || (val_i[1:0] == 2'b10);
        key_ok_o   = (val_i == kpc_pkg::RESET_KEY);
    end

endmodule

// File: rtl/kpc_cmd_decoder.sv
// Keypad controller command decoder and register file.
// Takes bytes from a serial slave front end (start, write byte, read
// request), runs the command set on the register file, flags bad
// parameters and unknown commands, and talks to the key FIFO through
// clear/pop/peek strobes. Reads are combinational while rd_req_i is high.
// Assumes at most one of start_i, wr_valid_i, rd_req_i per cycle.
module kpc_cmd_decoder #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             wr_valid_i,
    input  logic [7:0]       wr_data_i,
    input  logic             rd_req_i,
    output logic [7:0]       rd_data_o,
    output logic             irq_n_o,
    output logic             fifo_clear_o,
    output logic             fifo_pop_o,
    output logic             fifo_peek_o,
    output logic [IDX_W-1:0] fifo_idx_o,
    input  logic [7:0]       fifo_data_i,
    output logic [7:0]       cfg_o,
    output logic [7:0]       active_time_o,
    output logic [7:0]       debounce_o,
    output logic [7:0]       key_size_o,
    output logic [7:0]       clock_o,
    output logic [15:0]      gpio_pull_o,
    output logic [15:0]      gpio_dir_o,
    output logic [15:0]      gpio_state_o
);
    import kpc_pkg::*;

    localparam logic [IDX_W-1:0] IDX_ZERO = '0;
    localparam logic [IDX_W-1:0] IDX_ONE  = 1;
    localparam logic [IDX_W-1:0] IDX_TWO  = 2;

    logic [7:0]       cmd;
    logic             live;
    logic [IDX_W-1:0] idx;
    logic             retire;
    logic             deb_bad, size_bad, clk_bad, key_ok;
    logic             wr_param, rd_byte, wr_known, rd_known;
    logic [1:0]       err_set;
    logic [7:0]       cfg_q, act_q, deb_q, size_q, clk_q, status_q, status_d, err_q;
    logic [15:0]      pull_q, dir_q, state_q;

    kpc_cmd_track #(.IDX_W(IDX_W)) u_track (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .rd_req_i(rd_req_i),
        .retire_i(retire), .cmd_o(cmd), .live_o(live), .idx_o(idx)
    );

    kpc_param_check u_check (
        .val_i(wr_data_i), .deb_bad_o(deb_bad), .size_bad_o(size_bad),
        .clk_bad_o(clk_bad), .key_ok_o(key_ok)
    );

    // Picks one byte of a 16-bit word by index; beyond byte 1 yields zero.
    function automatic logic [7:0] pick16(input logic [15:0] w, input logic [IDX_W-1:0] i);
        if (i == IDX_ZERO)     return w[7:0];
        else if (i == IDX_ONE) return w[15:8];
        else                   return 8'h00;
    endfunction

    assign wr_param = wr_valid_i && !start_i && idx != IDX_ZERO;
    assign rd_byte  = rd_req_i && !start_i;

    // Classify the live command by direction and decide retirement.
    always_comb begin
        wr_known = 1'b0;
        rd_known = 1'b0;
        retire   = 1'b0;
        case (cmd)
            OP_CFG_WR, OP_SOFT_RST, OP_ACT_WR, OP_DEB_WR, OP_SIZE_WR, OP_CLK_WR: begin
                wr_known = 1'b1;
                retire   = wr_param && live;
            end
            OP_PULL_WR, OP_DIR_WR, OP_STATE_WR: begin
                wr_known = 1'b1;
                retire   = wr_param && live && idx == IDX_TWO;
            end
            OP_ID_RD, OP_STAT_RD, OP_DIR_RD, OP_STATE_RD, OP_FIFO_POP, OP_FIFO_PEEK,
            OP_ERR_RD, OP_ROT_RD, OP_SIZE_RD, OP_CFG_RD, OP_CLK_RD:
                rd_known = 1'b1;
            default: ;
        endcase
    end

    // Error sources for this cycle: bad parameter and unknown command.
    always_comb begin
        err_set = 2'b00;
        if (wr_param && !live)
            err_set[ERR_BADPAR] = 1'b1;
        if (wr_param && live) begin
            if ((cmd == OP_SOFT_RST && !key_ok) || (cmd == OP_DEB_WR && deb_bad) ||
                (cmd == OP_SIZE_WR && size_bad) || (cmd == OP_CLK_WR && clk_bad))
                err_set[ERR_BADPAR] = 1'b1;
            if (!wr_known)
                err_set[ERR_CMDUNK] = 1'b1;
        end
        if (rd_byte && (!live || !rd_known))
            err_set[ERR_CMDUNK] = 1'b1;
    end

    // Next status: read-clear, config clear, soft reset, error flag.
    always_comb begin
        status_d = status_q;
        if (rd_byte && live && cmd == OP_STAT_RD && !status_q[ST_NOINIT])
            status_d = 8'h00;
        if (wr_param && live && cmd == OP_CFG_WR)
            status_d = 8'h00;
        if (wr_param && live && cmd == OP_SOFT_RST && key_ok)
            status_d = RST_STATUS;
        if (err_set != 2'b00)
            status_d[ST_ERROR] = 1'b1;
    end

    // Status and sticky error registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= RST_STATUS;
            err_q    <= 8'h00;
        end else begin
            status_q <= status_d;
            err_q    <= err_q | {6'b0, err_set};
        end
    end

    // Configuration and GPIO register file updates from parameter bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= RST_CFG;
            act_q   <= RST_ACTIVE;
            deb_q   <= RST_DEBOUNCE;
            size_q  <= RST_SIZE;
            clk_q   <= RST_CLOCK;
            pull_q  <= 16'h0000;
            dir_q   <= 16'h0000;
            state_q <= 16'h0000;
        end else if (wr_param && live) begin
            case (cmd)
                OP_CFG_WR:  cfg_q  <= wr_data_i;
                OP_ACT_WR:  act_q  <= wr_data_i;
                OP_DEB_WR:  deb_q  <= wr_data_i;
                OP_SIZE_WR: size_q <= wr_data_i;
                OP_CLK_WR:  clk_q  <= wr_data_i;
                OP_SOFT_RST: if (key_ok) begin
                    cfg_q  <= RST_CFG;
                    act_q  <= RST_ACTIVE;
                    deb_q  <= RST_DEBOUNCE;
                    size_q <= RST_SIZE;
                    clk_q  <= RST_CLOCK;
                end
                OP_PULL_WR:  pull_q  <= (idx == IDX_ONE) ? {8'h00, wr_data_i} : (pull_q  | {wr_data_i, 8'h00});
                OP_DIR_WR:   dir_q   <= (idx == IDX_ONE) ? {8'h00, wr_data_i} : (dir_q   | {wr_data_i, 8'h00});
                OP_STATE_WR: state_q <= (idx == IDX_ONE) ? {8'h00, wr_data_i} : (state_q | {wr_data_i, 8'h00});
                default: ;
            endcase
        end
    end

    // Read data multiplexer, with readback shaping per command.
    always_comb begin
        rd_data_o = 8'h00;
        if (rd_byte && live) begin
            case (cmd)
                OP_ID_RD:     rd_data_o = pick16(ID_WORD, idx);
                OP_STAT_RD:   rd_data_o = pick16({8'h00, status_q}, idx);
                OP_DIR_RD:    rd_data_o = pick16(dir_q, idx);
                OP_STATE_RD:  rd_data_o = pick16(state_q, idx);
                OP_FIFO_POP,
                OP_FIFO_PEEK: rd_data_o = fifo_data_i;
                OP_ERR_RD:    rd_data_o = err_q;
                OP_SIZE_RD:   rd_data_o = size_q;
                OP_CFG_RD:    rd_data_o = {4'h0, cfg_q[3:0]};
                OP_CLK_RD:    rd_data_o = {clk_q[7:2], 2'b10};
                default:      rd_data_o = 8'h00;
            endcase
        end
    end

    assign irq_n_o       = (status_q == 8'h00);
    assign fifo_clear_o  = wr_param && live && cmd == OP_CFG_WR;
    assign fifo_pop_o    = rd_byte && live && cmd == OP_FIFO_POP;
    assign fifo_peek_o   = rd_byte && live && cmd == OP_FIFO_PEEK;
    assign fifo_idx_o    = idx;
    assign cfg_o         = cfg_q;
    assign active_time_o = act_q;
    assign debounce_o    = deb_q;
    assign key_size_o    = size_q;
    assign clock_o       = clk_q;
    assign gpio_pull_o   = pull_q;
    assign gpio_dir_o    = dir_q;
    assign gpio_state_o  = state_q;

    assert_cfg_clears_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clear_o |=> (status_q == 8'h00 && irq_n_o));

    assert_soft_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_param && live && cmd == OP_SOFT_RST && wr_data_i == RESET_KEY)
        |=> (cfg_q == RST_CFG && status_q == RST_STATUS && clk_q == RST_CLOCK));

    assert_error_sets_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_set != 2'b00) |=> status_q[ST_ERROR]);

    assert_noinit_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[ST_NOINIT] && rd_byte && live && cmd == OP_STAT_RD) |=> status_q[ST_NOINIT]);

    assert_error_sticky_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q & $past(err_q)) == $past(err_q));

endmodule

// File: tb/test_kpc_cmd_decoder.sv
// Scoreboard bench: driver tasks queue expected read bytes, a monitor
// compares them against rd_data_o in the middle of each read cycle.
module test_kpc_cmd_decoder;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, wr_valid = 1'b0, rd_req = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data, fifo_data;
    logic irq_n, fifo_clear, fifo_pop, fifo_peek;
    logic [3:0] fifo_idx;
    logic [7:0] cfg, act, deb, ksize, clkreg;
    logic [15:0] pull, dir, gstate;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    assign fifo_data = 8'hA0 | {4'h0, fifo_idx};

    kpc_cmd_decoder i_kpc_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .start_i(start), .wr_valid_i(wr_valid),
        .wr_data_i(wr_data), .rd_req_i(rd_req), .rd_data_o(rd_data),
        .irq_n_o(irq_n), .fifo_clear_o(fifo_clear), .fifo_pop_o(fifo_pop),
        .fifo_peek_o(fifo_peek), .fifo_idx_o(fifo_idx), .fifo_data_i(fifo_data),
        .cfg_o(cfg), .active_time_o(act), .debounce_o(deb), .key_size_o(ksize),
        .clock_o(clkreg), .gpio_pull_o(pull), .gpio_dir_o(dir), .gpio_state_o(gstate)
    );

    task automatic chk(input string tag, input logic [15:0] actual, input logic [15:0] expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, actual, expected);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic begin_xfer;
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    task automatic put(input logic [7:0] d);
        wr_valid = 1'b1;
        wr_data  = d;
        tick();
        wr_valid = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] c);
        begin_xfer();
        put(c);
    endtask

    task automatic get(input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        rd_req = 1'b1;
        tick();
        rd_req = 1'b0;
    endtask

    task automatic read_status(input logic [7:0] e, input string tag);
        cmd(8'h82);
        begin_xfer();
        get(e, tag);
    endtask

    // Monitor: compare each read byte against the scoreboard head.
    always @(negedge clk) begin
        if (rd_req) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R2 scoreboard: actual unexpected read %h expected none", rd_data);
            end else begin
                chk(tag_q.pop_front(), {8'h00, rd_data}, {8'h00, exp_q.pop_front()});
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog: actual hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 cfg", {8'h0, cfg}, 16'h0080);
        chk("R1 active", {8'h0, act}, 16'd125);
        chk("R1 debounce", {8'h0, deb}, 16'd3);
        chk("R1 size", {8'h0, ksize}, 16'h0033);
        chk("R1 clock", {8'h0, clkreg}, 16'h0008);
        chk("R1 gpio dir", dir, 16'h0000);
        chk("R1 irq low", {15'h0, irq_n}, 16'h0000);

        // R11 status read keeps not-initialised bit
        read_status(8'h10, "R11 status noinit");
        chk("R11 irq still low", {15'h0, irq_n}, 16'h0000);

        // R3 config write clears status, pulses FIFO clear
        cmd(8'h81);
        wr_valid = 1'b1; wr_data = 8'h5A;
        #1 chk("R3 fifo clear pulse", {15'h0, fifo_clear}, 16'h0001);
        tick(); wr_valid = 1'b0;
        chk("R3 cfg stored", {8'h0, cfg}, 16'h005A);
        chk("R3 irq released", {15'h0, irq_n}, 16'h0001);
        cmd(8'h92); begin_xfer();
        get(8'h0A, "R3 cfg low nibble");

        // R6 active time, R9 extra byte after retirement
        cmd(8'h8B); put(8'h40);
        chk("R6 active stored", {8'h0, act}, 16'h0040);
        chk("R6 no error yet", {15'h0, irq_n}, 16'h0001);
        put(8'h11);
        chk("R9 extra byte irq", {15'h0, irq_n}, 16'h0000);
        chk("R9 active unchanged", {8'h0, act}, 16'h0040);
        cmd(8'h8C); begin_xfer();
        get(8'h01, "R9 badpar bit");
        read_status(8'h08, "R10 status error bit");
        chk("R11 irq after clear", {15'h0, irq_n}, 16'h0001);
        read_status(8'h00, "R11 status cleared");

        // R5 GPIO 16-bit writes and indexed reads
        cmd(8'h85); put(8'h34); put(8'h12);
        chk("R5 dir", dir, 16'h1234);
        cmd(8'h87); begin_xfer();
        get(8'h34, "R5 dir low"); get(8'h12, "R5 dir high"); get(8'h00, "R5 dir beyond");
        cmd(8'h85); put(8'h00);
        chk("R5 low write clears high", dir, 16'h0000);
        put(8'h00);
        cmd(8'h84); put(8'hFF); put(8'h01);
        chk("R5 pull", pull, 16'h01FF);
        cmd(8'h86); put(8'h0F); put(8'hA0);
        chk("R5 state", gstate, 16'hA00F);
        cmd(8'h88); begin_xfer();
        get(8'h0F, "R5 state low"); get(8'hA0, "R5 state high");
        chk("R5 no error", {15'h0, irq_n}, 16'h0001);

        // R6 debounce
        cmd(8'h8F); put(8'h00);
        chk("R6 debounce zero stored", {8'h0, deb}, 16'h0000);
        chk("R6 debounce zero error", {15'h0, irq_n}, 16'h0000);
        read_status(8'h08, "R6 status after debounce");
        cmd(8'h8F); put(8'h05);
        chk("R6 debounce 5", {8'h0, deb}, 16'h0005);
        chk("R6 debounce 5 no error", {15'h0, irq_n}, 16'h0001);

        // R7 keypad size
        cmd(8'h90); put(8'h8C);
        chk("R7 size edge legal", {15'h0, irq_n}, 16'h0001);
        cmd(8'h91); begin_xfer();
        get(8'h8C, "R7 size read");
        cmd(8'h90); put(8'h93);
        chk("R7 high nibble 9 error", {15'h0, irq_n}, 16'h0000);
        read_status(8'h08, "R7 status clear");
        cmd(8'h90); put(8'h32);
        chk("R7 low nibble 2 error", {15'h0, irq_n}, 16'h0000);
        read_status(8'h08, "R7 status clear 2");

        // R8 clock
        cmd(8'h93); put(8'h01);
        chk("R8 clock 01 error", {15'h0, irq_n}, 16'h0000);
        read_status(8'h08, "R8 status clear");
        cmd(8'h94); begin_xfer();
        get(8'h02, "R8 clock readback forced");
        cmd(8'h93); put(8'hF3);
        chk("R8 clock stored", {8'h0, clkreg}, 16'h00F3);
        chk("R8 clock 11 legal", {15'h0, irq_n}, 16'h0001);
        cmd(8'h94); begin_xfer();
        get(8'hF2, "R8 clock readback");

        // R10 unknown command on write and read
        cmd(8'h8D); put(8'h00);
        chk("R10 unknown write irq", {15'h0, irq_n}, 16'h0000);
        cmd(8'h8C); begin_xfer();
        get(8'h03, "R14 error bits accumulate");
        read_status(8'h08, "R10 status clear");
        cmd(8'h99); begin_xfer();
        get(8'h00, "R10 unknown read zero");
        chk("R10 unknown read irq", {15'h0, irq_n}, 16'h0000);
        read_status(8'h08, "R10 status clear 2");

        // R12 ID read, R2 index restart
        cmd(8'h80); begin_xfer();
        get(8'h00, "R12 id byte0"); get(8'h04, "R12 id byte1"); get(8'h00, "R12 id byte2");
        begin_xfer();
        get(8'h00, "R2 restart byte0"); get(8'h04, "R2 restart byte1");

        // R13 FIFO peek and pop
        cmd(8'h8A); begin_xfer();
        rd_req = 1'b1;
        #1 chk("R13 peek strobe", {15'h0, fifo_peek}, 16'h0001);
        chk("R13 peek index 0", {12'h0, fifo_idx}, 16'h0000);
        rd_req = 1'b0;
        get(8'hA0, "R13 peek data 0");
        get(8'hA1, "R13 peek data 1");
        cmd(8'h89); begin_xfer();
        rd_req = 1'b1;
        #1 chk("R13 pop strobe", {15'h0, fifo_pop}, 16'h0001);
        chk("R13 no peek on pop", {15'h0, fifo_peek}, 16'h0000);
        rd_req = 1'b0;
        get(8'hA0, "R13 pop data");

        // R4 soft reset command
        cmd(8'h83); put(8'h55);
        chk("R4 bad key cfg kept", {8'h0, cfg}, 16'h005A);
        chk("R4 bad key irq", {15'h0, irq_n}, 16'h0000);
        cmd(8'h83); put(8'hAA);
        chk("R4 cfg restored", {8'h0, cfg}, 16'h0080);
        chk("R4 active restored", {8'h0, act}, 16'd125);
        chk("R4 debounce restored", {8'h0, deb}, 16'd3);
        chk("R4 size restored", {8'h0, ksize}, 16'h0033);
        chk("R4 clock restored", {8'h0, clkreg}, 16'h0008);
        chk("R4 gpio kept", gstate, 16'hA00F);
        cmd(8'h8C); begin_xfer();
        get(8'h03, "R14 error survives soft reset");
        read_status(8'h10, "R4 status noinit");
        read_status(8'h10, "R11 noinit not cleared");

        tick(); tick();
        chk("R2 scoreboard drained", 16'(exp_q.size()), 16'h0000);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule